// File: doc/BRIEF.md
# Ping-Pong Video Buffer Engine

This block takes a continuous stream of pixel words from a camera front end and stores it in a pool of equal-sized on-chip buffers, so that the stream keeps flowing while earlier data is still being read out. The buffers are owned by two producer chains. Chain 0 owns the even buffers and chain 1 owns the odd ones. Writing alternates between the chains, so one buffer fills while the previous full one waits for the consumer. The fill order is therefore 0, 1, 2, … 7, and then it wraps.

Every buffer begins with a 16-byte header. Pixel data never lands in the header. When a buffer closes, either because its payload region is full or because a frame ended, the header is written with a sequence number, the frame, line and pixel position of the first stored word, a valid-length field and flags. Only after that is the buffer handed to the consumer. With these headers, a receiver can place every word without counting from the first word it ever saw.

The consumer reads the buffers through a valid/ready port in strict buffer order: header words first, then payload words. A buffer returns to the free pool only when its last word has been taken. If the buffer that a chain needs next is still held, arriving words are discarded, a sticky overflow flag is set and a drop counter is incremented.

Top module: `vdma_pingpong`

## Requirements
- R1: The header of each buffer is 16 bytes, little-endian, and is read out first. Its fields are:
  - bytes 0–3: sequence number;
  - bytes 4–5: frame number;
  - bytes 6–7: line number;
  - bytes 8–9: pixel offset;
  - bytes 10–11: valid payload length in words;
  - byte 12: flags (bit 0 = frame start, bit 1 = frame end);
  - bytes 13–15: zero.

  With 16-bit words, the header occupies words 0–7 in that byte order. The sequence number is 0 for the first buffer committed after reset and rises by one for each commit.
- R2: Buffers fill on two alternating chains (chain 0 = even indices, chain 1 = odd indices), giving the order 0,1,…,NUM_BUF-1 and then a wrap. The consumer drains them in that same order, and payload words leave in arrival order.
- R3: While the next buffer needed by the active chain is still committed and not fully read, every arriving word is discarded. On each such word, `overflow` goes high and stays high until reset, and `dropCount` increments, saturating at its maximum.
- R4: A buffer becomes free only on the cycle in which its last word is accepted (`rdLast`=1 with `rdReady`=1). A word that arrives before that cycle is dropped; a word that arrives after it is stored.
- R5: A buffer closes when its payload region is full or when it stores a word marked frame end. The length field equals the number of payload words stored. The buffer becomes readable one cycle after the closing word, once its header is in place. The consumer sees exactly 8 + length words (16-bit config), with `rdLast` on the final one. Flag bit 1 is set exactly when a frame-end word closed the buffer, including when that word also fills the last slot.
- R6: The frame, line and pixel fields give the position of the first payload word, counted over every valid input word, dropped words included:
  - a frame-start word sets frame = previous + 1, line = 0 and pixel = 0;
  - otherwise a line-start word sets line + 1 and pixel = 0;
  - otherwise pixel + 1.

  After reset, frame and pixel act as all-ones and line as 0, so the first frame is frame 0.
- R7: Flag bit 0 is set exactly when a word stored in the buffer carried the frame-start marker.
- R8: Words arriving on consecutive cycles across buffer boundaries are all stored when the next buffer is free. No cycle is lost at a chain switch.
- R9: After reset, `rdValid`, `overflow` and `dropCount` are zero.
- R10: While `rdValid` is high and `rdReady` is low, `rdValid` stays high and `rdData` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Input word present this cycle |
| pixData | input | DATA_W | Input pixel word |
| pixFrameStart | input | 1 | Word is the first of a frame |
| pixLineStart | input | 1 | Word is the first of a line |
| pixFrameEnd | input | 1 | Word is the last of a frame |
| rdValid | output | 1 | Read word available |
| rdReady | input | 1 | Consumer accepts the word |
| rdData | output | DATA_W | Read word (header, then payload) |
| rdLast | output | 1 | Final word of the current buffer |
| overflow | output | 1 | Sticky: a word was dropped |
| dropCount | output | DROP_W | Number of dropped words |

## Verification
The closing of a buffer on a full payload region and on a frame-end marker can fall in the same cycle when a frame ends exactly on the last payload slot. The frame-length sweep of 1 to 9 words puts the end marker on every slot position, including the fourth and eighth words. It is judged by a single commit with full length and the end flag set, and by an unbroken sequence number in the next buffer. Release and claim of one buffer are also provoked back to back: a word arrives while the final header-plus-payload word is still outstanding and must be dropped, and a word arriving right after the release must be stored.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [1:0] {
    B_FREE = 2'd0,
    B_FILL = 2'd1,
    B_FULL = 2'd2
  } bstate_e;

  // strobes from control to datapath; fields sized for the largest config
  typedef struct packed {
    logic        wrEn;
    logic        capFirst;
    logic        hdrWr;
    logic        endFlag;
    logic [7:0]  wrBuf;
    logic [15:0] wrOff;
    logic [15:0] hdrLen;
    logic [7:0]  rdBuf;
    logic [15:0] rdIdx;
  } vdma_ctl_t;

endpackage

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BUF   = 8,
  parameter int BUF_WORDS = 32,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              pixFrameEnd,
  input  logic              rdReady,
  output vdma_ctl_t         ctl,
  output logic              rdValid,
  output logic              rdLast,
  output logic              overflow,
  output logic [DROP_W-1:0] dropCount
);
  localparam int HDR_WORDS = 128 / DATA_W;
  localparam int PAY_WORDS = BUF_WORDS - HDR_WORDS;
  localparam int BUF_W     = $clog2(NUM_BUF);
  localparam int PTR_W     = BUF_W - 1;
  localparam int OFF_W     = $clog2(BUF_WORDS + 1);

  bstate_e          bufState [NUM_BUF];
  logic [OFF_W-1:0] lenReg   [NUM_BUF];
  logic [PTR_W-1:0] chainPtr [2];
  logic             activeChain;
  logic [BUF_W-1:0] wrBuf, pendBuf, rdBuf;
  logic [OFF_W-1:0] wrCount, rdIdx, lastIdx;
  logic             accept, drop, closeBuf, pendValid, rdFire;

  // one write pointer per producer chain, each stepping through its own buffers
  for (genvar gc = 0; gc < 2; gc++) begin : g_chain
    logic [PTR_W-1:0] ptr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptr <= '0;
      else if (closeBuf && activeChain == 1'(gc)) ptr <= ptr + PTR_W'(1);
    end
    assign chainPtr[gc] = ptr;
  end

  assign wrBuf    = {chainPtr[activeChain], activeChain};
  assign accept   = pixValid && (bufState[wrBuf] != B_FULL);
  assign drop     = pixValid && (bufState[wrBuf] == B_FULL);
  assign closeBuf = accept && (pixFrameEnd || wrCount == OFF_W'(PAY_WORDS - 1));

  assign rdValid = (bufState[rdBuf] == B_FULL);
  assign lastIdx = OFF_W'(HDR_WORDS - 1) + lenReg[rdBuf];
  assign rdLast  = rdValid && (rdIdx == lastIdx);
  assign rdFire  = rdValid && rdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeChain <= 1'b0;
      wrCount     <= '0;
      pendValid   <= 1'b0;
      pendBuf     <= '0;
    end else begin
      pendValid <= closeBuf;
      pendBuf   <= wrBuf;
      if (closeBuf) begin
        wrCount     <= '0;
        activeChain <= ~activeChain;
      end else if (accept) begin
        wrCount <= wrCount + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) lenReg[i] <= '0;
    end else if (closeBuf) begin
      lenReg[wrBuf] <= wrCount + OFF_W'(1);
    end
  end

  // ownership: commit after header write, release after last read, claim on first word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) bufState[i] <= B_FREE;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (pendValid && pendBuf == BUF_W'(i))                 bufState[i] <= B_FULL;
        else if (rdFire && rdLast && rdBuf == BUF_W'(i))       bufState[i] <= B_FREE;
        else if (accept && wrBuf == BUF_W'(i))                 bufState[i] <= B_FILL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBuf <= '0;
      rdIdx <= '0;
    end else if (rdFire) begin
      if (rdLast) begin
        rdIdx <= '0;
        rdBuf <= rdBuf + BUF_W'(1);
      end else begin
        rdIdx <= rdIdx + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      dropCount <= '0;
    end else if (drop) begin
      overflow <= 1'b1;
      if (dropCount != '1) dropCount <= dropCount + DROP_W'(1);
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.wrEn     = accept;
    ctl.capFirst = accept && (wrCount == '0);
    ctl.hdrWr    = closeBuf;
    ctl.endFlag  = pixFrameEnd;
    ctl.wrBuf    = 8'(wrBuf);
    ctl.wrOff    = 16'(wrCount);
    ctl.hdrLen   = 16'(wrCount) + 16'd1;
    ctl.rdBuf    = 8'(rdBuf);
    ctl.rdIdx    = 16'(rdIdx);
  end

  // R5: a buffer is still owned by the writer while its header commit is pending
  p_hdr_before_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> bufState[pendBuf] == B_FILL);

  // R3: overflow never clears once set
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R3: the drop counter moves only when the target buffer is held
  p_no_spurious_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && bufState[wrBuf] != B_FULL) |=> dropCount == $past(dropCount));

  // R4: a buffer stays committed until its last word is taken
  p_release_on_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdFire && !rdLast) |=> bufState[$past(rdBuf)] == B_FULL);

  // R2: each close hands writing to the other chain
  p_chain_alternates_r2: assert property (@(posedge clk) disable iff (!rstN)
    closeBuf |=> wrBuf[0] != $past(wrBuf[0]));

endmodule

// File: rtl/vdma_dpath.sv
module vdma_dpath
  import vdma_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BUF   = 8,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  vdma_ctl_t         ctl,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixFrameStart,
  input  logic              pixLineStart,
  output logic [DATA_W-1:0] rdData
);
  localparam int HDR_WORDS = 128 / DATA_W;
  localparam int PAY_WORDS = BUF_WORDS - HDR_WORDS;
  localparam int MEM_WORDS = NUM_BUF * PAY_WORDS;
  localparam int ADDR_W    = $clog2(MEM_WORDS);
  localparam int BUF_W     = $clog2(NUM_BUF);
  localparam int HIDX_W    = $clog2(HDR_WORDS);

  logic [DATA_W-1:0] payMem [MEM_WORDS];
  logic [127:0]      hdrMem [NUM_BUF];
  logic [15:0]       posFrame, posLine, posPix, curFrame, curLine, curPix;
  logic [15:0]       firstFrame, firstLine, firstPix, effFrame, effLine, effPix;
  logic              sofSeen, effSof;
  logic [31:0]       seqNo;
  logic [127:0]      hdrWord;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [BUF_W-1:0]  hdrBuf, rdBuf;
  logic [HIDX_W-1:0] hSel;

  // position of the word on the input this cycle
  always_comb begin
    curFrame = posFrame;
    curLine  = posLine;
    curPix   = posPix + 16'd1;
    if (pixFrameStart) begin
      curFrame = posFrame + 16'd1;
      curLine  = '0;
      curPix   = '0;
    end else if (pixLineStart) begin
      curLine = posLine + 16'd1;
      curPix  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posFrame <= '1;
      posLine  <= '0;
      posPix   <= '1;
    end else if (pixValid) begin
      posFrame <= curFrame;
      posLine  <= curLine;
      posPix   <= curPix;
    end
  end

  // first-word capture, bypassed when the first word also closes the buffer
  assign effFrame = ctl.capFirst ? curFrame : firstFrame;
  assign effLine  = ctl.capFirst ? curLine  : firstLine;
  assign effPix   = ctl.capFirst ? curPix   : firstPix;
  assign effSof   = (ctl.capFirst ? 1'b0 : sofSeen) | (ctl.wrEn & pixFrameStart);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstFrame <= '0;
      firstLine  <= '0;
      firstPix   <= '0;
      sofSeen    <= 1'b0;
      seqNo      <= '0;
    end else begin
      if (ctl.wrEn) begin
        firstFrame <= effFrame;
        firstLine  <= effLine;
        firstPix   <= effPix;
        sofSeen    <= effSof;
      end
      if (ctl.hdrWr) seqNo <= seqNo + 32'd1;
    end
  end

  always_comb begin
    hdrWord         = '0;
    hdrWord[31:0]   = seqNo;
    hdrWord[47:32]  = effFrame;
    hdrWord[63:48]  = effLine;
    hdrWord[79:64]  = effPix;
    hdrWord[95:80]  = ctl.hdrLen;
    hdrWord[96]     = effSof;
    hdrWord[97]     = ctl.endFlag;
  end

  assign hdrBuf = BUF_W'(ctl.wrBuf);
  assign wrAddr = ADDR_W'(int'(ctl.wrBuf) * PAY_WORDS + int'(ctl.wrOff));

  always_ff @(posedge clk) begin
    if (ctl.wrEn) payMem[wrAddr] <= pixData;
    if (ctl.hdrWr) hdrMem[hdrBuf] <= hdrWord;
  end

  // read mux: header words from the side file, payload from the pool
  assign rdBuf  = BUF_W'(ctl.rdBuf);
  assign hSel   = HIDX_W'(ctl.rdIdx);
  assign rdAddr = ADDR_W'(int'(ctl.rdBuf) * PAY_WORDS + int'(ctl.rdIdx) - HDR_WORDS);

  always_comb begin
    if (int'(ctl.rdIdx) < HDR_WORDS) rdData = hdrMem[rdBuf][hSel*DATA_W +: DATA_W];
    else                             rdData = payMem[rdAddr];
  end

endmodule

// File: rtl/vdma_pingpong.sv
module vdma_pingpong
  import vdma_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BUF   = 8,
  parameter int BUF_WORDS = 32,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixFrameStart,
  input  logic              pixLineStart,
  input  logic              pixFrameEnd,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic              overflow,
  output logic [DROP_W-1:0] dropCount
);
  vdma_ctl_t ctl;

  vdma_ctrl #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .DROP_W(DROP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixFrameEnd(pixFrameEnd),
    .rdReady(rdReady), .ctl(ctl), .rdValid(rdValid), .rdLast(rdLast),
    .overflow(overflow), .dropCount(dropCount)
  );

  vdma_dpath #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixValid(pixValid), .pixData(pixData),
    .pixFrameStart(pixFrameStart), .pixLineStart(pixLineStart), .rdData(rdData)
  );

  // R10: a stalled read word holds still
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

endmodule

// File: tb/vdma_pingpong_tb_top.sv
`timescale 1ns/1ps
module vdma_pingpong_tb_top;
  localparam int DW = 16, NB = 8, BW = 12, HW = 8, PW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 0, pixFrameStart = 0, pixLineStart = 0, pixFrameEnd = 0, rdReady = 0;
  logic [DW-1:0] pixData = '0;
  logic rdValid, rdLast, overflow;
  logic [DW-1:0] rdData;
  logic [15:0] dropCount;

  always #2 clk = ~clk;

  vdma_pingpong #(.DATA_W(DW), .NUM_BUF(NB), .BUF_WORDS(BW), .DROP_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .pixFrameStart(pixFrameStart), .pixLineStart(pixLineStart), .pixFrameEnd(pixFrameEnd),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .rdLast(rdLast),
    .overflow(overflow), .dropCount(dropCount)
  );

  int vecs = 0, fails = 0, done = 0;
  int expW [0:1023]; int expK [0:1023]; int expN = 0;
  int gotW [0:1023]; int gotN = 0;
  int pushIdx = 0;
  logic [15:0] bF, bL, bP;
  int mCnt, mSeq, mSof;
  logic [15:0] mF, mL, mP;
  int mPay [0:PW-1];

  task automatic chk(input longint act, input longint exp, input string req, input string what);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int k);
    if (k < 2 || k == 7) return "R1";
    if (k <= 4) return "R6";
    if (k == 5) return "R5";
    if (k == 6) return "R7";
    return "R2";
  endfunction

  // collector: records every word the consumer takes
  always @(negedge clk) begin
    #1;
    if (rstN && rdValid && rdReady && gotN < 1024) begin
      gotW[gotN] = int'(rdData);
      gotN++;
    end
  end

  task automatic emitBuf(input int eof);
    logic [127:0] h;
    h = '0;
    h[31:0]  = 32'(mSeq);
    h[47:32] = mF;
    h[63:48] = mL;
    h[79:64] = mP;
    h[95:80] = 16'(mCnt);
    h[96]    = mSof[0];
    h[97]    = eof[0];
    for (int k = 0; k < HW; k++) begin
      expW[expN] = int'(h[16*k +: 16]); expK[expN] = k; expN++;
    end
    for (int j = 0; j < mCnt; j++) begin
      expW[expN] = mPay[j]; expK[expN] = HW + j; expN++;
    end
    mSeq++; mCnt = 0; mSof = 0;
  endtask

  task automatic push(input int acc, input int sof, input int sol, input int eof);
    logic [15:0] d;
    d = 16'(pushIdx * 37 + 5);
    @(negedge clk);
    pixValid = 1; pixData = d;
    pixFrameStart = sof[0]; pixLineStart = sol[0]; pixFrameEnd = eof[0];
    if (sof != 0) begin bF = bF + 1; bL = 0; bP = 0; end
    else if (sol != 0) begin bL = bL + 1; bP = 0; end
    else bP = bP + 1;
    if (acc != 0) begin
      if (mCnt == 0) begin mF = bF; mL = bL; mP = bP; end
      mPay[mCnt] = int'(d);
      if (sof != 0) mSof = 1;
      mCnt++;
      if (mCnt == PW || eof != 0) emitBuf(eof);
    end
    pushIdx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValid = 0; pixFrameStart = 0; pixLineStart = 0; pixFrameEnd = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; rdReady = 0; pixValid = 0;
    pixFrameStart = 0; pixLineStart = 0; pixFrameEnd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    bF = 16'hFFFF; bL = 0; bP = 16'hFFFF;
    mCnt = 0; mSeq = 0; mSof = 0; expN = 0; gotN = 0; pushIdx = 0;
    #1;
    chk(rdValid, 0, "R9", "rdValid after reset");
    chk(overflow, 0, "R9", "overflow after reset");
    chk(dropCount, 0, "R9", "dropCount after reset");
  endtask

  task automatic compareAll(input string tag);
    chk(gotN, expN, "R2", {tag, " word count"});
    for (int i = 0; i < expN && i < gotN; i++)
      chk(gotW[i], expW[i], reqOf(expK[i]), $sformatf("%s word %0d", tag, i));
  endtask

  initial begin
    // scenario A: consumer always ready; burst then frame-length sweep
    doReset();
    @(negedge clk); rdReady = 1;
    for (int i = 0; i < 32; i++) push(1, (i == 0) ? 1 : 0, 0, 0);   // R8 back-to-back
    idle(150);
    for (int len = 1; len <= 9; len++) begin                       // R5: end on every slot
      for (int i = 0; i < len; i++) begin
        push(1, (i == 0) ? 1 : 0, (i > 0 && i % 3 == 0) ? 1 : 0, (i == len - 1) ? 1 : 0);
        idle(4);
      end
      idle(2);
    end
    idle(300);
    chk(dropCount, 0, "R8", "no drops at full rate");
    chk(overflow, 0, "R8", "no overflow at full rate");
    compareAll("sweep");

    // scenario B: stalled consumer, overflow and release timing
    doReset();
    for (int i = 0; i < 34; i++) push((i < 32) ? 1 : 0, (i == 0) ? 1 : 0, 0, 0);
    idle(3);
    chk(overflow, 1, "R3", "overflow sticky set");
    chk(dropCount, 2, "R3", "drop count after pool full");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(rdValid, 1, "R10", "valid held while stalled");
      chk(rdData, 0, "R10", "data held while stalled");
    end
    for (int i = 0; i < HW + PW - 1; i++) begin @(negedge clk); rdReady = 1; end
    @(negedge clk); rdReady = 0;
    push(0, 0, 0, 0);                                              // R4: before release
    idle(2);
    chk(dropCount, 3, "R4", "word dropped before last read");
    #1;
    chk(rdLast, 1, "R4", "last word flagged");
    @(negedge clk); rdReady = 1;
    @(negedge clk); rdReady = 0;
    push(1, 0, 0, 0);                                              // R4: after release
    push(1, 0, 0, 1);
    idle(3);
    chk(dropCount, 3, "R4", "word stored after release");
    chk(overflow, 1, "R3", "overflow still set");
    @(negedge clk); rdReady = 1;
    idle(200);
    compareAll("stall");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (done == 0) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule